// File: doc/BRIEF.md
# Serial Video Output Playback Port

This block is the playback side of a sequential video memory. A sixteen-word holding store, twelve bits per word, is filled in one step from the memory read path. A separate transfer strobe copies the store into a sixteen-stage output ring. A port shift clock then presents the ring's words one at a time on a twelve-bit output. If no new transfer arrives, the ring wraps around, so the sixteen words play again in the same order and the output never runs dry.

All control inputs (memory enable, port select, transfer strobe, shift clock, output enable) are treated as slow levels. They are sampled in a single system clock domain through two flip-flops each, and their edges are found from the sampled values. The port shift clock can therefore run with no relation to the clocks of other ports. Two instances can serve two independent read ports. The output enable does not gate the data word. It appears as a separate registered drive signal, and a tri-state pad outside the block turns that signal into a floating bus.

The data interface uses strobes, not a valid/ready handshake. No back-pressure exists: a transfer always overwrites the ring, and a memory load always overwrites the store.

Top module: `sop_port`

## Requirements
- R1: While reset is asserted, and up to the first input edge after it, `out_word` is 0 and `out_drive` is 0.
- R2: A falling edge of `mem_en` while `port_sel` is 1 copies `fill_words` into the holding store. Word i occupies bits [i*12 +: 12].
- R3: A falling edge of `mem_en` while `port_sel` is 0 leaves the holding store unchanged. A later transfer shows the older contents.
- R4: A falling edge of `xfer_strobe` copies the holding store into the output ring and presents store word 0 on `out_word`.
- R5: Each rising edge of `shift_clk` with no transfer edge in the same cycle advances `out_word` to the next ring word.
- R6: After 16 shift edges with no transfer, the words repeat in the same order: word 15 is followed by word 0.
- R7: When a transfer edge and a shift edge are detected in the same cycle, the ring reloads and presents word 0.
- R8: Loading the holding store does not change `out_word`. Rising edges of `xfer_strobe` and falling edges of `shift_clk` have no effect.
- R9: `out_drive` follows `out_enable`. When it is 0, the data pins must be high impedance.
- R10: An input change made before system clock edge n takes effect on the outputs right after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mem_en | input | 1 | Memory enable; its falling edge loads the store |
| port_sel | input | 1 | Mode decode: 1 selects this port for the memory load |
| fill_words | input | 192 | Sixteen 12-bit words from the memory read path |
| xfer_strobe | input | 1 | Read-transfer strobe; its falling edge loads the ring |
| shift_clk | input | 1 | Port shift clock; its rising edge advances the word |
| out_enable | input | 1 | Output enable request |
| out_word | output | 12 | Current output word, registered |
| out_drive | output | 1 | Pad drive enable; 0 means the bus floats |

## Verification
The assertions assume that `fill_words` holds still from the `mem_en` fall until the store has captured it. They also assume that every strobe level lasts long enough for the two-flop sampler to see it. The stimulus meets both assumptions: it holds each control level for at least two system clocks, and it keeps the memory data constant for four cycles after each enable fall. The bench compares the outputs on every clock against a behavioural reference model. That model tracks a read index into a word array; it does not rotate a ring.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/sop_edge.sv
module sop_edge
  import sop_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic pulse
);
  logic s0, s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s0 <= din;
      s1 <= s0;
      s2 <= s1;
    end
  end

  assign level = s1;

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign pulse = s1 & ~s2;
    end else begin : g_fall
      assign pulse = ~s1 & s2;
    end
  endgenerate

  // R10: a detected edge lasts one cycle only
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/sop_latch.sv
module sop_latch #(
  parameter int WORD_W = 12,
  parameter int DEPTH  = 16,
  localparam int BUS_W = WORD_W * DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] load_data,
  output logic [BUS_W-1:0] store
);
  always_ff @(posedge clk) begin
    if (!rst_n)    store <= '0;
    else if (load) store <= load_data;
  end

  // R3: without a qualified load the store holds
  p_store_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(store));
  // R2: a qualified load captures the memory words
  p_store_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> store == $past(load_data));
endmodule

// File: rtl/sop_ring.sv
module sop_ring #(
  parameter int WORD_W = 12,
  parameter int DEPTH  = 16,
  localparam int BUS_W = WORD_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              advance,
  input  logic [BUS_W-1:0]  reload_data,
  output logic [WORD_W-1:0] head
);
  logic [WORD_W-1:0] ring [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else if (reload) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= reload_data[i*WORD_W +: WORD_W];
    end else if (advance) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= ring[(i + 1) % DEPTH];
    end
  end

  assign head = ring[0];

  // R4/R7: a reload presents word 0, even with a coincident advance
  p_reload_word0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> head == $past(reload_data[WORD_W-1:0]));
  // R5/R6: an advance presents the following word, wrapping at the end
  p_advance_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reload) |=> head == $past(ring[1 % DEPTH]));
  // R8: without reload or advance the head does not change
  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !reload) |=> $stable(head));
endmodule

// File: rtl/sop_port.sv
module sop_port
  import sop_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int DEPTH  = 16,
  localparam int BUS_W = WORD_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              port_sel,
  input  logic [BUS_W-1:0]  fill_words,
  input  logic              xfer_strobe,
  input  logic              shift_clk,
  input  logic              out_enable,
  output logic [WORD_W-1:0] out_word,
  output logic              out_drive
);
  logic mem_lvl, mem_fall;
  logic sel_lvl, sel_unused;
  logic xf_lvl, xf_fall;
  logic sh_lvl, sh_rise;
  logic oe_lvl, oe_unused;
  logic [BUS_W-1:0] store;

  sop_edge #(.KIND(EDGE_FALL)) u_mem (.clk(clk), .rst_n(rst_n), .din(mem_en),
    .level(mem_lvl), .pulse(mem_fall));
  sop_edge #(.KIND(EDGE_RISE)) u_sel (.clk(clk), .rst_n(rst_n), .din(port_sel),
    .level(sel_lvl), .pulse(sel_unused));
  sop_edge #(.KIND(EDGE_FALL)) u_xfr (.clk(clk), .rst_n(rst_n), .din(xfer_strobe),
    .level(xf_lvl), .pulse(xf_fall));
  sop_edge #(.KIND(EDGE_RISE)) u_shf (.clk(clk), .rst_n(rst_n), .din(shift_clk),
    .level(sh_lvl), .pulse(sh_rise));
  sop_edge #(.KIND(EDGE_RISE)) u_oe (.clk(clk), .rst_n(rst_n), .din(out_enable),
    .level(oe_lvl), .pulse(oe_unused));

  sop_latch #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(mem_fall & sel_lvl),
    .load_data(fill_words), .store(store));

  sop_ring #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .reload(xf_fall), .advance(sh_rise),
    .reload_data(store), .head(out_word));

  always_ff @(posedge clk) begin
    if (!rst_n) out_drive <= 1'b0;
    else        out_drive <= oe_lvl;
  end

  // R9: the pad drive follows the sampled enable one cycle later
  p_drive_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_drive == $past(oe_lvl));
  // R8: a store load alone leaves the presented word alone
  p_load_no_disturb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fall && !xf_fall && !sh_rise) |=> $stable(out_word));
  // R4: a transfer presents store word 0
  p_xfer_word0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xf_fall |=> out_word == $past(store[WORD_W-1:0]));

  logic unused_ok;
  assign unused_ok = ^{mem_lvl, sel_unused, xf_lvl, sh_lvl, oe_unused};
endmodule

// File: tb/sop_port_bench.sv
module sop_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_en = 1'b0, port_sel = 1'b0, xfer_strobe = 1'b0;
  logic shift_clk = 1'b0, out_enable = 1'b0;
  logic [W*D-1:0] fill_words = '0;
  logic [W-1:0] out_word;
  logic out_drive;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_port u_sop_port (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .port_sel(port_sel),
    .fill_words(fill_words), .xfer_strobe(xfer_strobe), .shift_clk(shift_clk),
    .out_enable(out_enable), .out_word(out_word), .out_drive(out_drive));

  // reference model: word array plus read index, fed by an input history
  typedef struct packed {logic me; logic sel; logic xf; logic sh; logic oe;} smp_t;
  smp_t hist[$];
  int unsigned m_store[D];
  int unsigned m_play[D];
  int m_idx;
  logic m_drive;

  function automatic int unsigned pat(int seed, int i);
    return (seed * 37 + i * 113 + 5) & 12'hFFF;
  endfunction

  task automatic model_reset();
    hist.delete();
    for (int k = 0; k < 4; k++) hist.push_back('0);
    for (int k = 0; k < D; k++) begin m_store[k] = 0; m_play[k] = 0; end
    m_idx = 0;
    m_drive = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      smp_t cur, a, b;
      bit ld, xf, sh;
      cur = '{me: mem_en, sel: port_sel, xf: xfer_strobe, sh: shift_clk, oe: out_enable};
      hist.push_front(cur);
      a = hist[2];
      b = hist[3];
      ld = b.me && !a.me && a.sel;
      xf = b.xf && !a.xf;
      sh = !b.sh && a.sh;
      if (xf) begin
        for (int k = 0; k < D; k++) m_play[k] = m_store[k];
        m_idx = 0;
      end else if (sh) m_idx = (m_idx + 1) % D;
      if (ld) for (int k = 0; k < D; k++) m_store[k] = fill_words[k*W +: W];
      m_drive = a.oe;
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (out_word !== m_play[m_idx][W-1:0] || out_drive !== m_drive) begin
        bad++;
        $display("FAIL %s: word=%h drive=%b expected word=%h drive=%b",
                 cur_req, out_word, out_drive, m_play[m_idx][W-1:0], m_drive);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int unsigned got, int unsigned exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic fill(int seed);
    for (int k = 0; k < D; k++) fill_words[k*W +: W] = pat(seed, k);
  endtask

  task automatic mem_load(int seed, logic sel);
    fill(seed);
    port_sel = sel;
    mem_en = 1'b1; tick(2);
    mem_en = 1'b0; tick(4);
  endtask

  task automatic do_xfer();
    xfer_strobe = 1'b1; tick(2);
    xfer_strobe = 1'b0; tick(3);
  endtask

  task automatic do_shift();
    shift_clk = 1'b1; tick(3);
    shift_clk = 1'b0; tick(2);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        $display("FAIL watchdog: actual=%0d cycles expected below 100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    tick(3);
    // R1: reset state
    check("R1", out_word, 0);
    check("R1", out_drive, 0);
    rst_n = 1'b1;
    tick(3);
    check("R1", out_word, 0);

    // R9 / R10: enable latency, counted in system clocks
    cur_req = "R10";
    out_enable = 1'b1;       // driven before edge n
    tick(2);                 // after edge n+1
    check("R10", out_drive, 0);
    tick(1);                 // after edge n+2
    check("R9", out_drive, 1);

    // R2 / R4 / R8: load the store, output must not move, then transfer
    cur_req = "R8";
    mem_load(1, 1'b1);
    check("R8", out_word, 0);
    cur_req = "R4";
    do_xfer();
    check("R4", out_word, pat(1, 0));

    // R5 / R6: walk all words and wrap
    cur_req = "R6";
    for (int k = 1; k <= D + 2; k++) begin
      do_shift();
      check(k <= D ? "R5" : "R6", out_word, pat(1, k % D));
    end

    // R3: unselected load is ignored, transfer shows old contents
    cur_req = "R3";
    mem_load(2, 1'b0);
    do_xfer();
    check("R3", out_word, pat(1, 0));

    // R2: selected load with a new pattern
    cur_req = "R2";
    mem_load(3, 1'b1);
    do_shift();
    check("R8", out_word, pat(1, 1));
    do_xfer();
    check("R2", out_word, pat(3, 0));
    do_shift(); do_shift();
    check("R2", out_word, pat(3, 2));

    // R7: transfer and shift edges in the same cycle
    cur_req = "R7";
    mem_load(4, 1'b1);
    xfer_strobe = 1'b1; tick(2);
    xfer_strobe = 1'b0; shift_clk = 1'b1; tick(4);
    check("R7", out_word, pat(4, 0));
    shift_clk = 1'b0; tick(2);
    do_shift();
    check("R7", out_word, pat(4, 1));

    // R8: rising transfer and falling shift edges do nothing
    cur_req = "R8";
    xfer_strobe = 1'b1; tick(4);
    check("R8", out_word, pat(4, 1));
    shift_clk = 1'b1; tick(3);
    check("R5", out_word, pat(4, 2));
    shift_clk = 1'b0; tick(4);
    check("R8", out_word, pat(4, 2));
    xfer_strobe = 1'b0; tick(4);
    check("R4", out_word, pat(4, 0));

    // R9: enable off floats the pad
    cur_req = "R9";
    out_enable = 1'b0; tick(4);
    check("R9", out_drive, 0);

    done = 1;
    tick(1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule